// File: doc/BRIEF.md
# Burst DRAM Refresh Controller

This block keeps a bank of asynchronous DRAM alive by running row refresh in short bursts. Each burst is eight strobe-only cycles: every cycle applies a row address and pulses the row strobe, with the column strobe left idle. Before it may drive the memory, the controller borrows the bus from the processor through a request, grant and acknowledge exchange. The bus goes back to the processor as soon as the eighth cycle of the burst has finished.

A slow periodic tick starts each burst. A level input running at one quarter of the system clock sets the pace of the refresh cycles: each of its periods is one refresh cycle. Both inputs are sampled by the system clock. The row address is nine bits wide. Its low three bits are the position inside the current burst and its high six bits are the burst number. The address is kept from one burst to the next, so successive bursts step through all 512 rows.

Top module: `burst_refresh_ctrl`

## Requirements
- R1: During and right after a synchronous reset, the bus request and acknowledge outputs (both active-low) are 1, refresh_active and refresh_ras are 0, and refresh_row is 0.
- R2: A clock edge that samples tick_in at 1, after it was 0 at the previous edge, drives bus_req_n to 0 after that same edge, provided no burst is pending or running.
- R3: While a request is pending, a rising edge of slow_clk that samples bus_grant_n at 0 sets refresh_active to 1 and returns bus_req_n to 1 at that same clock edge. A request and refresh_active are never asserted together.
- R4: bus_ack_n is 0 exactly when refresh_active is 1.
- R5: Each burst produces exactly eight refresh_ras pulses. refresh_ras is 1 only while refresh_active is 1 and slow_clk was sampled low.
- R6: refresh_row = {burst number (bits 8:3), position (bits 2:0)}. The position advances by one on each rising edge of slow_clk while a burst is active, and the burst number advances when the position wraps from 7 to 0. During the k-th pulse of a burst (k = 0..7) the position equals k.
- R7: The eighth slow_clk rising edge of a burst clears refresh_active, so bus_ack_n returns to 1 with the position back at 0.
- R8: A rising edge of tick_in while a request is pending or a burst is running is ignored and starts no later burst.
- R9: refresh_row does not change outside bursts. Each burst starts where the previous one stopped, and the address wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Periodic refresh tick; its rising edge starts a burst |
| slow_clk | input | 1 | System clock divided by four, sampled as a level |
| bus_grant_n | input | 1 | Bus grant from the processor, active low |
| bus_req_n | output | 1 | Bus request to the processor, active low |
| bus_ack_n | output | 1 | Bus grant acknowledge, active low; low while refresh owns the bus |
| refresh_active | output | 1 | High while a burst owns the bus |
| refresh_ras | output | 1 | Row strobe pulse for each refresh cycle, active high |
| refresh_row | output | 9 | Row address being refreshed |

## Verification
Three events can fall on the same clock edge: the eighth rise of slow_clk, which ends the burst, clears the position and steps the burst number; the increment of the row address; and a new tick edge. Fresh ticks are also raised while a request is pending and in the middle of a burst. The bench checks that none of them produces a second request, either then or after the bus has been released. It runs 66 bursts back to back, so the row address goes through its 511-to-0 wrap. At every burst start the row is compared with a count kept in the bench, and every pulse is compared with its arithmetic position.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  parameter int unsigned RF_POS_W   = 3;
  parameter int unsigned RF_BURST_W = 6;
endpackage

// File: rtl/rfsh_edge.sv
module rfsh_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/rfsh_rowcnt.sv
module rfsh_rowcnt #(
  parameter int unsigned POS_W   = 3,
  parameter int unsigned BURST_W = 6,
  localparam int unsigned ROW_W  = POS_W + BURST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic             last_o,
  output logic [ROW_W-1:0] row_o
);
  logic [POS_W-1:0]   pos_q;
  logic [BURST_W-1:0] burst_q;

  assign last_o = &pos_q;
  assign row_o  = {burst_q, pos_q};

  // inner counter: position inside the burst
  always_ff @(posedge clk) begin
    if (rst)         pos_q <= '0;
    else if (step_i) pos_q <= pos_q + 1'b1;
  end

  // outer counter: advances on the inner wrap
  always_ff @(posedge clk) begin
    if (rst)                   burst_q <= '0;
    else if (step_i && last_o) burst_q <= burst_q + 1'b1;
  end
endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic tick_rise_i,
  input  logic slow_rise_i,
  input  logic slow_lvl_i,
  input  logic grant_n_i,
  input  logic burst_last_i,
  output logic req_o,
  output logic active_o,
  output logic ras_o,
  output logic step_o
);
  logic req_d, act_d;

  assign step_o = active_o & slow_rise_i;

  always_comb begin
    req_d = req_o;
    act_d = active_o;
    if (!req_o && !active_o && tick_rise_i) req_d = 1'b1;
    if (req_o && slow_rise_i && !grant_n_i) begin
      req_d = 1'b0;
      act_d = 1'b1;
    end
    if (active_o && slow_rise_i && burst_last_i) act_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o    <= 1'b0;
      active_o <= 1'b0;
      ras_o    <= 1'b0;
    end else begin
      req_o    <= req_d;
      active_o <= act_d;
      ras_o    <= act_d & ~slow_lvl_i;
    end
  end
endmodule

// File: rtl/burst_refresh_ctrl.sv
module burst_refresh_ctrl #(
  parameter int unsigned POS_W   = rfsh_pkg::RF_POS_W,
  parameter int unsigned BURST_W = rfsh_pkg::RF_BURST_W,
  localparam int unsigned ROW_W  = POS_W + BURST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             slow_clk,
  input  logic             bus_grant_n,
  output logic             bus_req_n,
  output logic             bus_ack_n,
  output logic             refresh_active,
  output logic             refresh_ras,
  output logic [ROW_W-1:0] refresh_row
);
  logic tick_rise, slow_rise, req, step, last;

  rfsh_edge u_tick_edge (.clk(clk), .rst(rst), .lvl_i(tick_in),  .rise_o(tick_rise));
  rfsh_edge u_slow_edge (.clk(clk), .rst(rst), .lvl_i(slow_clk), .rise_o(slow_rise));

  rfsh_arbiter u_arb (
    .clk(clk), .rst(rst), .tick_rise_i(tick_rise), .slow_rise_i(slow_rise),
    .slow_lvl_i(slow_clk), .grant_n_i(bus_grant_n), .burst_last_i(last),
    .req_o(req), .active_o(refresh_active), .ras_o(refresh_ras), .step_o(step)
  );

  rfsh_rowcnt #(.POS_W(POS_W), .BURST_W(BURST_W)) u_row (
    .clk(clk), .rst(rst), .step_i(step), .last_o(last), .row_o(refresh_row)
  );

  assign bus_req_n = ~req;
  assign bus_ack_n = ~refresh_active;
endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
  parameter int unsigned POS_W = 3,
  parameter int unsigned ROW_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req_n,
  input logic             bus_ack_n,
  input logic             refresh_active,
  input logic             refresh_ras,
  input logic [ROW_W-1:0] refresh_row
);
  localparam logic [ROW_W-1:0] ONE = {{(ROW_W-1){1'b0}}, 1'b1};

  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!bus_req_n && refresh_active));
  // R3
  grant_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_active) |-> $past(!bus_req_n));
  // R4
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_n == !refresh_active));
  // R5
  ras_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_ras |-> refresh_active);
  // R7
  burst_end_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(refresh_active) |-> (refresh_row[POS_W-1:0] == '0));
  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!refresh_active) |-> $stable(refresh_row));
  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(refresh_row) |-> (refresh_row == $past(refresh_row) + ONE));
endmodule

bind burst_refresh_ctrl rfsh_checker #(.POS_W(POS_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n),
  .refresh_active(refresh_active), .refresh_ras(refresh_ras),
  .refresh_row(refresh_row)
);

// File: tb/tb_burst_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_burst_refresh_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0;
  logic slow_clk;
  logic bus_grant_n = 1'b1;
  logic bus_req_n, bus_ack_n, refresh_active, refresh_ras;
  logic [8:0] refresh_row;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [1:0] sdiv = 2'd0;
  int gcnt = 0;
  int exp_row = 0;

  burst_refresh_ctrl dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .slow_clk(slow_clk),
    .bus_grant_n(bus_grant_n), .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n),
    .refresh_active(refresh_active), .refresh_ras(refresh_ras),
    .refresh_row(refresh_row)
  );

  always #10 clk = ~clk;
  assign slow_clk = sdiv[1];

  always @(negedge clk) begin
    if (rst) sdiv <= 2'd0;
    else     sdiv <= sdiv + 2'd1;
  end

  // processor model: grants six cycles after a request, drops the grant with it
  always @(negedge clk) begin
    if (bus_req_n) begin
      gcnt <= 0;
      bus_grant_n <= 1'b1;
    end else if (gcnt == 5) bus_grant_n <= 1'b0;
    else gcnt <= gcnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    nchk = nchk + 1;
    if (act != expv) begin
      nfail = nfail + 1;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_burst(input int idx);
    int rises = 0;
    bit prev_ras = 1'b0;
    bit seen = 1'b0;
    @(negedge clk) tick_in = 1'b1;
    @(posedge clk) #2;
    chk("R2 request after tick", int'(bus_req_n), 0);
    @(negedge clk) tick_in = 1'b0;
    @(negedge clk) tick_in = 1'b1;   // edge while pending
    @(negedge clk) tick_in = 1'b0;
    chk("R8 request held while pending", int'(bus_req_n), 0);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk) #2;
      if (refresh_active) begin seen = 1'b1; break; end
    end
    chk("R3 burst granted", int'(seen), 1);
    chk("R3 request released", int'(bus_req_n), 1);
    chk("R4 ack low in burst", int'(bus_ack_n), 0);
    chk("R9 row at burst start", int'(refresh_row), exp_row);
    for (int i = 0; i < 100; i++) begin
      if (i == 5) tick_in = 1'b1;    // edge while running
      if (i == 9) tick_in = 1'b0;
      @(posedge clk) #2;
      if (bus_ack_n != !refresh_active) chk("R4 ack tracks active", int'(bus_ack_n), int'(!refresh_active));
      if (refresh_ras && !refresh_active) chk("R5 ras outside burst", 1, 0);
      if (refresh_ras && !prev_ras) begin
        chk("R6 position during pulse", int'(refresh_row[2:0]), rises);
        chk("R6 burst field during pulse", int'(refresh_row[8:3]), (exp_row >> 3) & 63);
        rises++;
      end
      prev_ras = refresh_ras;
      if (!refresh_active) break;
    end
    tick_in = 1'b0;
    chk("R5 pulses per burst", rises, 8);
    chk("R7 bus released", int'(bus_ack_n), 1);
    chk("R7 position wrapped", int'(refresh_row[2:0]), 0);
    exp_row = (exp_row + 8) % 512;
    chk("R6 row after burst", int'(refresh_row), exp_row);
    repeat (12) @(posedge clk);
    #2;
    chk("R8 no extra request", int'(bus_req_n), 1);
    chk("R8 no extra burst", int'(refresh_active), 0);
    chk("R9 row held idle", int'(refresh_row), exp_row);
    if (idx == 63) chk("R9 wrap to zero", int'(refresh_row), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2;
    chk("R1 req_n reset", int'(bus_req_n), 1);
    chk("R1 ack_n reset", int'(bus_ack_n), 1);
    chk("R1 active reset", int'(refresh_active), 0);
    chk("R1 ras reset", int'(refresh_ras), 0);
    chk("R1 row reset", int'(refresh_row), 0);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 idle after reset", int'(bus_req_n), 1);
    for (int b = 0; b < 66; b++) run_burst(b);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule